// File: doc/BRIEF.md
# Posted Write Buffer with Line Eviction Path

This block sits between a processor's data cache and the system bus and lets stores retire without waiting for the bus. Bufferable writes go into a main queue. The queue keeps a small ring of address entries apart from a larger pool of data words, so one address entry can describe a run of consecutive words. Each entry drains as one burst, and the oldest entry goes first. A write carries a two-bit memory attribute that decides whether it may be posted. A write that may not be posted waits until everything ahead of it has left the block, so ordering is preserved.

Dirty lines that the cache evicts or cleans never enter the main queue. They go to a dedicated single-line buffer that holds one base address and a full line of words. That line leaves as its own burst, and it is slotted in only at a boundary between main-queue bursts.

The bus side is a valid/ready beat handshake. The burst base address and the beat count stay fixed for the whole burst, and a flag marks the final beat.

Top module: `wr_post_buf`

## Requirements
- R1: After synchronous reset, `bus_valid` is 0, `ev_ready` is 1, and `wr_ready` is 1 for a bufferable write.
- R2: A bufferable write whose word address equals the youngest entry's base plus its word count joins that entry. The entry then leaves as one burst: `bus_addr` holds the base, `bus_len` holds the word count (1 to DDEPTH), and the data comes out in arrival order.
- R3: A bufferable write that cannot join the youngest entry opens a new entry. Entries leave strictly oldest first, one burst per entry.
- R4: A write presented with `wr_last`=1 closes its entry, so the next write always opens a new entry, even if its address is consecutive.
- R5: `wr_ready` is 0 when all DDEPTH data words are occupied. It is also 0 when all ADEPTH address entries are occupied and the write cannot join the youngest entry.
- R6: `wr_attr` encoding: 2'b01 noncacheable-bufferable, 2'b10 write-through and 2'b11 write-back miss are posted at once. 2'b00 (not bufferable) is accepted only when the main queue is empty, no burst is in progress and the eviction buffer holds no word. It then leaves alone as a one-beat burst.
- R7: An eviction line of LINE words is taken through the `ev_` port one word per handshake. The address of the first word is the line base. The line leaves as one LINE-beat burst with `bus_evict`=1, base address and words in order.
- R8: `ev_ready` stays 0 from the acceptance of a line's last word until the final beat of its eviction burst has been handshaken.
- R9: An eviction burst never starts inside a main-queue burst. If a full line and a main entry are both waiting at a burst boundary, the eviction goes first.
- R10: While `bus_valid`=1 and `bus_ready`=0, all bus outputs hold. `bus_last` is 1 on the final beat of each burst and on no other beat.
- R11: The oldest entry starts draining only once it is closed, or a younger entry exists, or no write was accepted in the previous cycle. This lets a back-to-back stream of consecutive writes coalesce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data word |
| wr_attr | input | 2 | Memory attribute (see R6) |
| wr_last | input | 1 | Closes the current entry after this word |
| ev_valid | input | 1 | Eviction word present |
| ev_ready | output | 1 | Eviction word accepted |
| ev_addr | input | AW | Line base address, sampled with the first word |
| ev_data | input | DW | Eviction data word |
| bus_valid | output | 1 | Beat present on the bus |
| bus_ready | input | 1 | Bus takes the beat |
| bus_addr | output | AW | Burst base word address |
| bus_data | output | DW | Beat data |
| bus_len | output | LEN_W | Beats in the current burst |
| bus_last | output | 1 | Final beat of the burst |
| bus_evict | output | 1 | Burst comes from the eviction buffer |

## Verification
The hardest situation to reach is a full line and a second main entry both waiting while a main burst is already locked on the bus. Only in that situation can the eviction arbitration go wrong. The bench reaches it by holding `bus_ready` low: it streams a main run until the head burst locks, then fills the eviction line and queues another run behind it. Only then does it release the bus, and it checks the exact burst order. Coalescing is swept over every run length from 1 to 16 under two different ready patterns, and the capacity limits are probed while the bus is held.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [1:0] {
    ATTR_NOBUF  = 2'b00,
    ATTR_NCBUF  = 2'b01,
    ATTR_WTHRU  = 2'b10,
    ATTR_WBMISS = 2'b11
  } wattr_e;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_MAIN  = 2'd1,
    DR_EVICT = 2'd2
  } drain_e;
endpackage

// File: rtl/wpb_data_fifo.sv
module wpb_data_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  p_data_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_data_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wpb_addr_q.sv
module wpb_addr_q #(
  parameter int AW     = 32,
  parameter int ADEPTH = 4,
  parameter int LEN_W  = 5,
  parameter int LMAX   = 16,
  parameter int CW     = $clog2(ADEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cand_addr,
  input  logic             lock_head,
  output logic             can_merge,
  input  logic             push_new,
  input  logic             append,
  input  logic             set_closed,
  input  logic             pop,
  output logic [AW-1:0]    head_base,
  output logic [LEN_W-1:0] head_len,
  output logic             head_closed,
  output logic [CW-1:0]    cnt
);
  localparam int PW = $clog2(ADEPTH);

  logic [AW-1:0]    base_r   [ADEPTH];
  logic [LEN_W-1:0] len_r    [ADEPTH];
  logic             closed_r [ADEPTH];
  logic [PW-1:0]    wp, rp, yi;

  assign yi = (wp == '0) ? PW'(ADEPTH - 1) : wp - 1'b1;

  assign can_merge = (cnt != '0) && !closed_r[yi] &&
                     !(lock_head && (yi == rp)) &&
                     (len_r[yi] != LEN_W'(LMAX)) &&
                     (cand_addr == base_r[yi] + AW'(len_r[yi]));

  always_ff @(posedge clk) begin
    if (push_new) begin
      base_r[wp]   <= cand_addr;
      len_r[wp]    <= LEN_W'(1);
      closed_r[wp] <= set_closed;
    end else if (append) begin
      len_r[yi]    <= len_r[yi] + 1'b1;
      closed_r[yi] <= set_closed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_new) wp <= (wp == PW'(ADEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)      rp <= (rp == PW'(ADEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_new) - CW'(pop);
    end
  end

  assign head_base   = base_r[rp];
  assign head_len    = len_r[rp];
  assign head_closed = closed_r[rp];

  p_addr_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push_new |-> (cnt < CW'(ADEPTH)));
  p_addr_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  p_push_xor_append_r2: assert property (@(posedge clk) disable iff (rst)
    !(push_new && append));
endmodule

// File: rtl/wpb_evict_buf.sv
module wpb_evict_buf #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LINE = 8,
  parameter int IW   = (LINE > 1) ? $clog2(LINE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] base,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          line_done
);
  localparam int CW = $clog2(LINE + 1);

  logic [DW-1:0] mem [LINE];
  logic [CW-1:0] wcnt;
  logic          take;

  assign take     = in_valid && in_ready;
  assign in_ready = (wcnt != CW'(LINE));
  assign full     = (wcnt == CW'(LINE));
  assign empty    = (wcnt == '0);
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (take) mem[IW'(wcnt)] <= in_data;
    if (take && wcnt == '0) base <= in_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)            wcnt <= '0;
    else if (line_done) wcnt <= '0;
    else if (take)      wcnt <= wcnt + 1'b1;
  end

  p_ev_done_only_full_r8: assert property (@(posedge clk) disable iff (rst)
    line_done |-> full);
  p_ev_stays_locked_r8: assert property (@(posedge clk) disable iff (rst)
    full && !line_done |=> full && !in_ready);
endmodule

// File: rtl/wr_post_buf.sv
module wr_post_buf
  import wpb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int ADEPTH = 4,
  parameter int DDEPTH = 16,
  parameter int LINE   = 8,
  parameter int LEN_W  = $clog2(((DDEPTH > LINE) ? DDEPTH : LINE) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       wr_attr,
  input  logic             wr_last,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [AW-1:0]    ev_addr,
  input  logic [DW-1:0]    ev_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_data,
  output logic [LEN_W-1:0] bus_len,
  output logic             bus_last,
  output logic             bus_evict
);
  localparam int ACW = $clog2(ADEPTH) + 1;
  localparam int DCW = $clog2(DDEPTH) + 1;
  localparam int IW  = (LINE > 1) ? $clog2(LINE) : 1;

  drain_e           dstate;
  logic [LEN_W-1:0] bcnt;
  logic             quiet_q;

  logic             is_nb, wr_fire, do_append, do_new, set_closed;
  logic             aq_merge, aq_head_closed, lock_head, head_ready;
  logic [AW-1:0]    aq_head_base;
  logic [LEN_W-1:0] aq_head_len;
  logic [ACW-1:0]   aq_cnt;
  logic             aq_pop, df_pop, df_full, df_empty;
  logic [DW-1:0]    df_head;
  logic [DCW-1:0]   df_count;
  logic             ev_full, ev_empty, ev_done;
  logic [AW-1:0]    ev_base;
  logic [IW-1:0]    ev_idx;
  logic [DW-1:0]    ev_word;
  logic             start_main, start_evict, beat_go;

  // ---------------- write acceptance ----------------
  assign is_nb      = (wr_attr == ATTR_NOBUF);
  assign wr_ready   = is_nb ? (aq_cnt == '0 && dstate == DR_IDLE && ev_empty)
                            : (!df_full && (aq_merge || aq_cnt < ACW'(ADEPTH)));
  assign wr_fire    = wr_valid && wr_ready;
  assign do_append  = wr_fire && !is_nb && aq_merge;
  assign do_new     = wr_fire && !do_append;
  assign set_closed = wr_last || is_nb;

  always_ff @(posedge clk) begin
    if (rst) quiet_q <= 1'b1;
    else     quiet_q <= !wr_fire;
  end

  // ---------------- drain arbitration ----------------
  assign head_ready  = (aq_cnt != '0) &&
                       ((aq_cnt > ACW'(1)) || aq_head_closed || quiet_q);
  assign start_evict = (dstate == DR_IDLE) && ev_full;
  assign start_main  = (dstate == DR_IDLE) && !ev_full && head_ready;
  assign lock_head   = (dstate == DR_MAIN) || start_main;
  assign beat_go     = bus_valid && bus_ready;

  assign df_pop  = start_main || (dstate == DR_MAIN && beat_go && !bus_last);
  assign aq_pop  = (dstate == DR_MAIN) && beat_go && bus_last;
  assign ev_done = (dstate == DR_EVICT) && beat_go && bus_last;
  assign ev_idx  = start_evict ? '0 : IW'(bcnt + LEN_W'(1));

  wpb_addr_q #(.AW(AW), .ADEPTH(ADEPTH), .LEN_W(LEN_W), .LMAX(DDEPTH)) u_aq (
    .clk(clk), .rst(rst), .cand_addr(wr_addr), .lock_head(lock_head),
    .can_merge(aq_merge), .push_new(do_new), .append(do_append),
    .set_closed(set_closed), .pop(aq_pop), .head_base(aq_head_base),
    .head_len(aq_head_len), .head_closed(aq_head_closed), .cnt(aq_cnt)
  );

  wpb_data_fifo #(.DW(DW), .DEPTH(DDEPTH)) u_df (
    .clk(clk), .rst(rst), .push(wr_fire), .push_data(wr_data),
    .pop(df_pop), .head(df_head), .count(df_count), .full(df_full),
    .empty(df_empty)
  );

  wpb_evict_buf #(.AW(AW), .DW(DW), .LINE(LINE)) u_ev (
    .clk(clk), .rst(rst), .in_valid(ev_valid), .in_ready(ev_ready),
    .in_addr(ev_addr), .in_data(ev_data), .full(ev_full), .empty(ev_empty),
    .base(ev_base), .rd_idx(ev_idx), .rd_data(ev_word), .line_done(ev_done)
  );

  // ---------------- registered bus master ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dstate    <= DR_IDLE;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      bus_len   <= '0;
      bus_last  <= 1'b0;
      bus_evict <= 1'b0;
      bcnt      <= '0;
    end else begin
      case (dstate)
        DR_IDLE: begin
          bcnt <= '0;
          if (start_evict) begin
            dstate    <= DR_EVICT;
            bus_valid <= 1'b1;
            bus_addr  <= ev_base;
            bus_len   <= LEN_W'(LINE);
            bus_data  <= ev_word;
            bus_last  <= (LINE == 1);
            bus_evict <= 1'b1;
          end else if (start_main) begin
            dstate    <= DR_MAIN;
            bus_valid <= 1'b1;
            bus_addr  <= aq_head_base;
            bus_len   <= aq_head_len;
            bus_data  <= df_head;
            bus_last  <= (aq_head_len == LEN_W'(1));
            bus_evict <= 1'b0;
          end
        end
        default: begin
          if (beat_go) begin
            if (bus_last) begin
              dstate    <= DR_IDLE;
              bus_valid <= 1'b0;
              bus_last  <= 1'b0;
            end else begin
              bus_data <= (dstate == DR_MAIN) ? df_head : ev_word;
              bcnt     <= bcnt + 1'b1;
              bus_last <= (bcnt + LEN_W'(2) == bus_len);
            end
          end
        end
      endcase
    end
  end

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
    $stable(bus_data) && $stable(bus_len) && $stable(bus_last) &&
    $stable(bus_evict));
  p_no_evict_midburst_r9: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready && !bus_last && !bus_evict |=> bus_valid && !bus_evict);
  p_nb_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && (wr_attr == ATTR_NOBUF) |->
    (aq_cnt == '0) && !bus_valid && df_empty);
  p_evict_len_r7: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_evict |-> (bus_len == LEN_W'(LINE)));
  p_data_bound_r5: assert property (@(posedge clk) disable iff (rst)
    df_count <= DCW'(DDEPTH));
endmodule

// File: tb/wr_post_buf_test.sv
module wr_post_buf_test;
  localparam int AW = 16, DW = 16, LW = 5, NREC = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, wr_last = 0, ev_valid = 0, bus_ready = 0;
  logic [AW-1:0] wr_addr = '0, ev_addr = '0;
  logic [DW-1:0] wr_data = '0, ev_data = '0;
  logic [1:0]    wr_attr = 2'b01;
  logic wr_ready, ev_ready, bus_valid, bus_last, bus_evict;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [LW-1:0] bus_len;

  wr_post_buf #(.AW(AW), .DW(DW), .ADEPTH(4), .DDEPTH(16), .LINE(8), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_attr(wr_attr), .wr_last(wr_last),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_data(ev_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_len(bus_len), .bus_last(bus_last), .bus_evict(bus_evict)
  );

  always #5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0, rec_cnt = 0, ridx = 0, ready_mode = 0;
  logic [AW-1:0] r_addr [NREC];
  logic [DW-1:0] r_data [NREC];
  logic [LW-1:0] r_len  [NREC];
  logic          r_last [NREC];
  logic          r_ev   [NREC];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // bus sink: ready chosen and beats recorded between edges
  always @(negedge clk) begin
    case (ready_mode)
      0:       bus_ready = 1'b0;
      1:       bus_ready = 1'b1;
      default: bus_ready = (cyc % 3) != 0;
    endcase
    if (bus_valid && bus_ready && rec_cnt < NREC) begin
      r_addr[rec_cnt] = bus_addr; r_data[rec_cnt] = bus_data;
      r_len[rec_cnt]  = bus_len;  r_last[rec_cnt] = bus_last;
      r_ev[rec_cnt]   = bus_evict;
      rec_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [1:0] at, input bit lst);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_attr = at; wr_last = lst;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 0; wr_last = 0; wr_attr = 2'b01;
  endtask

  task automatic probe_wr(input logic [AW-1:0] a, input logic [1:0] at,
                          input bit exp, input string req);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_attr = at;
    #1;
    chk(wr_ready == exp, req, int'(wr_ready), int'(exp));
    wr_valid = 0; wr_attr = 2'b01;
  endtask

  task automatic ev_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ev_valid = 1; ev_addr = a; ev_data = d;
    #1;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  // one check per burst: base, length, data sequence, last flag, source
  task automatic exp_burst(input logic [AW-1:0] base, input int len, input bit ev,
                           input logic [DW-1:0] seed, input string req);
    int t = 0;
    bit ok = 1;
    int act = 0, ex = 0;
    while (rec_cnt < ridx + len && t < 3000) begin @(negedge clk); t++; end
    for (int i = 0; i < len; i++) begin
      if (ok && (r_addr[ridx+i] != base || r_len[ridx+i] != LW'(len) ||
                 r_data[ridx+i] != seed + DW'(i) || r_ev[ridx+i] != ev ||
                 r_last[ridx+i] != (i == len - 1) || ridx + i >= rec_cnt)) begin
        ok = 0;
        act = {r_addr[ridx+i], r_data[ridx+i]};
        ex  = {base, seed + DW'(i)};
      end
    end
    chk(ok, req, act, ex);
    ridx += len;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk(bus_valid == 0, "R1 bus_valid", int'(bus_valid), 0);
    chk(wr_ready == 1,  "R1 wr_ready",  int'(wr_ready), 1);
    chk(ev_ready == 1,  "R1 ev_ready",  int'(ev_ready), 1);

    // R2 R11 R10 sweep of run length under held bus, then two ready patterns
    for (int n = 1; n <= 16; n++) begin
      ready_mode = 0;
      for (int i = 0; i < n; i++)
        wr(AW'(n * 32 + i), DW'(n * 256 + i), 2'(i % 3 + 1), 0);
      if (n == 16) probe_wr(AW'(n * 32 + 16), 2'b01, 0, "R5 data full");
      ready_mode = (n % 2) ? 1 : 2;
      exp_burst(AW'(n * 32), n, 0, DW'(n * 256), "R2 R11 R10 merged run");
    end

    // R3 R5: four entries, then a fifth distinct address stalls
    ready_mode = 0;
    for (int e = 1; e <= 4; e++)
      for (int i = 0; i < e; i++)
        wr(AW'(16'h1000 * e + i), DW'(16'h700 + 16 * e + i), 2'b10, 0);
    probe_wr(16'h5000, 2'b01, 0, "R5 address entries full");
    ready_mode = 2;
    for (int e = 1; e <= 4; e++)
      exp_burst(AW'(16'h1000 * e), e, 0, DW'(16'h700 + 16 * e), "R3 oldest first");

    // R4: last flag splits a consecutive run
    ready_mode = 0;
    wr(16'h0300, 16'hA0, 2'b01, 0);
    wr(16'h0301, 16'hA1, 2'b01, 1);
    wr(16'h0302, 16'hB0, 2'b11, 0);
    wr(16'h0303, 16'hB1, 2'b11, 0);
    ready_mode = 1;
    exp_burst(16'h0300, 2, 0, 16'hA0, "R4 closed entry");
    exp_burst(16'h0302, 2, 0, 16'hB0, "R4 next entry");

    // R6: attributes, non-bufferable waits for drain and stands alone
    ready_mode = 0;
    wr(16'h0400, 16'hC0, 2'b01, 0);
    wr(16'h0401, 16'hC1, 2'b10, 0);
    wr(16'h0402, 16'hC2, 2'b11, 0);
    probe_wr(16'h0403, 2'b00, 0, "R6 non-bufferable held");
    ready_mode = 1;
    wr(16'h0403, 16'hD0, 2'b00, 0);
    wr(16'h0404, 16'hE0, 2'b01, 0);
    exp_burst(16'h0400, 3, 0, 16'hC0, "R6 posted attrs");
    exp_burst(16'h0403, 1, 0, 16'hD0, "R6 non-bufferable alone");
    exp_burst(16'h0404, 1, 0, 16'hE0, "R6 no merge after non-bufferable");

    // R7 R8: lone eviction line
    ready_mode = 0;
    for (int i = 0; i < 8; i++) ev_wr(AW'(16'h0800 + i), DW'(16'h5000 + i));
    @(negedge clk); #1;
    chk(ev_ready == 0, "R8 ev_ready low while full", int'(ev_ready), 0);
    ready_mode = 2;
    exp_burst(16'h0800, 8, 1, 16'h5000, "R7 eviction burst");
    @(negedge clk); @(negedge clk); #1;
    chk(ev_ready == 1, "R8 ev_ready after write-out", int'(ev_ready), 1);

    // R9: full line waiting behind a locked main burst and ahead of another entry
    ready_mode = 0;
    for (int i = 0; i < 4; i++) wr(AW'(16'h0900 + i), DW'(16'h900 + i), 2'b01, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) ev_wr(16'h0880, DW'(16'h6000 + i));
    wr(16'h0A00, 16'hAA0, 2'b10, 0);
    wr(16'h0A01, 16'hAA1, 2'b10, 0);
    ready_mode = 1;
    exp_burst(16'h0900, 4, 0, 16'h900, "R9 main burst completes");
    exp_burst(16'h0880, 8, 1, 16'h6000, "R9 eviction at boundary");
    exp_burst(16'h0A00, 2, 0, 16'hAA0, "R9 main resumes");

    repeat (20) @(negedge clk);
    chk(rec_cnt == ridx, "R3 no extra beats", rec_cnt, ridx);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule